// File: doc/BRIEF.md
# Oscillator Control Word Loader

This block sits between a host command port and the control registers of a numerically controlled oscillator. The host drives a 16-bit data word, a two-bit address, an active-low chip select and a write strobe. The strobe is sampled in the block's clock domain. On each detected rising edge, the addressed input staging register captures the data word. There are three of these registers: a low frequency half, a high frequency half and a phase word.

The two frequency halves together form a 32-bit word. That word is copied into one of three wide target registers: the carrier (center) frequency, the frequency offset or the timer step. Each target has its own active-low enable. Each enable passes through one register stage before it acts on its target. While a registered enable stays low, its target takes a fresh copy of the combined halves on every clock. Any later update to a half therefore flows into that target one clock after the half changes.

Top module: `cmd_load_if`

## Requirements
- R1: After reset, all three staging registers and all three target registers read zero.
- R2: Address code 0 (binary 00) with chip select low loads `lo_half` from `cmd_data` on the clock edge where a strobe rise is detected. The other staging registers are untouched.
- R3: Address code 1 (binary 01) with chip select low loads `hi_half` from `cmd_data` on the strobe-rise edge. The other staging registers are untouched.
- R4: Address code 2 (binary 10) with chip select low loads `phase_word` from `cmd_data` on the strobe-rise edge. The other staging registers are untouched.
- R5: Address code 3 (binary 11) is reserved. A write to it changes no register.
- R6: While `cs_n` is high, a strobe rise changes no staging register, whatever the address.
- R7: A strobe rise is detected only when the strobe was sampled low on one clock edge and high on the next. A strobe held high loads once, and changes to `cmd_data` while it stays high have no effect.
- R8: A target enable sampled low on clock edge k leaves its target unchanged at edge k. The target loads `{hi_half, lo_half}` (high half in bits 31:16) at edge k+1.
- R9: While a target's registered enable is low, the target reloads on every clock. A staging-half update at edge e appears in the target after edge e+1.
- R10: Each enable affects only its own target (`ctr_n` to `ctr_freq`, `off_n` to `off_freq`, `tim_n` to `tim_step`). A target whose registered enable is high holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_data | input | 16 | Host command data word |
| cmd_addr | input | 2 | Staging register select |
| cs_n | input | 1 | Active-low chip select |
| wr_strb | input | 1 | Write strobe, sampled in the clock domain |
| ctr_n | input | 1 | Active-low load enable for the center frequency |
| off_n | input | 1 | Active-low load enable for the frequency offset |
| tim_n | input | 1 | Active-low load enable for the timer step |
| lo_half | output | 16 | Low frequency staging half |
| hi_half | output | 16 | High frequency staging half |
| phase_word | output | 16 | Phase staging word |
| ctr_freq | output | 32 | Center frequency target |
| off_freq | output | 32 | Frequency offset target |
| tim_step | output | 32 | Timer step target |

## Verification
The bench builds the block with its default 16-bit data width, so that a target is exactly two halves wide. With the two-bit address, every address and chip-select combination can be swept with several data patterns. Each pattern is generated arithmetically, and its expected result is predicted by a model of the staging registers kept in the bench. For each enable, the bench times the delay from the enable falling to the target load, the continued reloading while the enable is held low, and the isolation between targets, all clock by clock.

// File: rtl/cmd_load_pkg.sv
package cmd_load_pkg;
  typedef enum logic [1:0] {
    ADR_LO  = 2'b00,
    ADR_HI  = 2'b01,
    ADR_PH  = 2'b10,
    ADR_RSV = 2'b11
  } cmd_addr_e;

  localparam int NUM_TGT = 3;
  localparam int TGT_CTR = 0;
  localparam int TGT_OFF = 1;
  localparam int TGT_TIM = 2;

  // true when a qualified write targets the given staging register
  function automatic logic write_hits(logic rise, logic cs_n, logic [1:0] adr,
                                      cmd_addr_e code);
    return rise && !cs_n && (adr == 2'(code));
  endfunction
endpackage

// File: rtl/cmd_wr_edge.sv
module cmd_wr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strb,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strb;
  end

  assign rise = strb & ~prev_q;
endmodule

// File: rtl/cmd_input_bank.sv
module cmd_input_bank
  import cmd_load_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              cs_n,
  input  logic [1:0]        adr,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] ph_q
);
  logic ld_lo, ld_hi, ld_ph;

  assign ld_lo = write_hits(rise, cs_n, adr, ADR_LO);
  assign ld_hi = write_hits(rise, cs_n, adr, ADR_HI);
  assign ld_ph = write_hits(rise, cs_n, adr, ADR_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      ph_q <= '0;
    end else begin
      if (ld_lo) lo_q <= data;
      if (ld_hi) hi_q <= data;
      if (ld_ph) ph_q <= data;
    end
  end
endmodule

// File: rtl/cmd_target_reg.sv
module cmd_target_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic [WORD_W-1:0] src,
  output logic              en_q,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b1;
      q    <= '0;
    end else begin
      en_q <= en_n;
      if (!en_q) q <= src;
    end
  end
endmodule

// File: rtl/cmd_load_if.sv
module cmd_load_if
  import cmd_load_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   cmd_data,
  input  logic [1:0]          cmd_addr,
  input  logic                cs_n,
  input  logic                wr_strb,
  input  logic                ctr_n,
  input  logic                off_n,
  input  logic                tim_n,
  output logic [DATA_W-1:0]   lo_half,
  output logic [DATA_W-1:0]   hi_half,
  output logic [DATA_W-1:0]   phase_word,
  output logic [2*DATA_W-1:0] ctr_freq,
  output logic [2*DATA_W-1:0] off_freq,
  output logic [2*DATA_W-1:0] tim_step
);
  localparam int WORD_W = 2 * DATA_W;

  logic                wr_rise;
  logic [WORD_W-1:0]   joined;
  logic [NUM_TGT-1:0]  en_raw_n;
  logic [NUM_TGT-1:0]  en_q;
  logic [WORD_W-1:0]   tgt_q [NUM_TGT];

  cmd_wr_edge edge_i (
    .clk(clk), .rst_n(rst_n), .strb(wr_strb), .rise(wr_rise)
  );

  cmd_input_bank #(.DATA_W(DATA_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .rise(wr_rise), .cs_n(cs_n), .adr(cmd_addr),
    .data(cmd_data), .lo_q(lo_half), .hi_q(hi_half), .ph_q(phase_word)
  );

  assign joined = {hi_half, lo_half};

  assign en_raw_n[TGT_CTR] = ctr_n;
  assign en_raw_n[TGT_OFF] = off_n;
  assign en_raw_n[TGT_TIM] = tim_n;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    cmd_target_reg #(.WORD_W(WORD_W)) tgt_i (
      .clk(clk), .rst_n(rst_n), .en_n(en_raw_n[g]), .src(joined),
      .en_q(en_q[g]), .q(tgt_q[g])
    );
  end

  assign ctr_freq = tgt_q[TGT_CTR];
  assign off_freq = tgt_q[TGT_OFF];
  assign tim_step = tgt_q[TGT_TIM];
endmodule

// File: rtl/cmd_load_if_chk.sv
module cmd_load_if_chk #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DATA_W-1:0]   cmd_data,
  input logic [1:0]          cmd_addr,
  input logic                cs_n,
  input logic                wr_strb,
  input logic                wr_rise,
  input logic [2:0]          en_q,
  input logic [DATA_W-1:0]   lo_half,
  input logic [DATA_W-1:0]   hi_half,
  input logic [DATA_W-1:0]   phase_word,
  input logic [2*DATA_W-1:0] ctr_freq,
  input logic [2*DATA_W-1:0] off_freq,
  input logic [2*DATA_W-1:0] tim_step
);
  p_lo_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !cs_n && cmd_addr == 2'b00) |=> (lo_half == $past(cmd_data)));
  p_hi_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !cs_n && cmd_addr == 2'b01) |=> (hi_half == $past(cmd_data)));
  p_ph_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !cs_n && cmd_addr == 2'b10) |=> (phase_word == $past(cmd_data)));
  p_rsv_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_addr == 2'b11) |=> $stable({lo_half, hi_half, phase_word}));
  p_cs_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable({lo_half, hi_half, phase_word}));
  p_held_strb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strb && $past(wr_strb)) |-> !wr_rise);
  p_ctr_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] |=> (ctr_freq == $past({hi_half, lo_half})));
  p_off_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[1] |=> (off_freq == $past({hi_half, lo_half})));
  p_tim_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[2] |=> (tim_step == $past({hi_half, lo_half})));
  p_ctr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[0] |=> $stable(ctr_freq));
  p_off_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[1] |=> $stable(off_freq));
  p_tim_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[2] |=> $stable(tim_step));
endmodule

bind cmd_load_if cmd_load_if_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
  .cs_n(cs_n), .wr_strb(wr_strb), .wr_rise(wr_rise), .en_q(en_q),
  .lo_half(lo_half), .hi_half(hi_half), .phase_word(phase_word),
  .ctr_freq(ctr_freq), .off_freq(off_freq), .tim_step(tim_step)
);

// File: tb/cmd_load_if_tb.sv
module cmd_load_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] cmd_data = '0;
  logic [1:0] cmd_addr = '0;
  logic cs_n = 1'b1, wr_strb = 1'b0;
  logic ctr_n = 1'b1, off_n = 1'b1, tim_n = 1'b1;
  logic [DW-1:0] lo_half, hi_half, phase_word;
  logic [2*DW-1:0] ctr_freq, off_freq, tim_step;

  int checks = 0, errors = 0;
  logic [DW-1:0] m_lo = '0, m_hi = '0, m_ph = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_load_if #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
    .cs_n(cs_n), .wr_strb(wr_strb), .ctr_n(ctr_n), .off_n(off_n), .tim_n(tim_n),
    .lo_half(lo_half), .hi_half(hi_half), .phase_word(phase_word),
    .ctr_freq(ctr_freq), .off_freq(off_freq), .tim_step(tim_step)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    chk(req, 32'(lo_half), 32'(m_lo));
    chk(req, 32'(hi_half), 32'(m_hi));
    chk(req, 32'(phase_word), 32'(m_ph));
  endtask

  // one strobe pulse; model updated from the requirement decode
  task automatic do_write(input logic [1:0] a, input logic [DW-1:0] d, input logic cs);
    @(negedge clk);
    cmd_addr = a; cmd_data = d; cs_n = cs; wr_strb = 1'b1;
    @(negedge clk);
    wr_strb = 1'b0;
    if (!cs) begin
      if (a == 2'd0) m_lo = d;
      else if (a == 2'd1) m_hi = d;
      else if (a == 2'd2) m_ph = d;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_bank("R1");
    chk("R1", ctr_freq, 0); chk("R1", off_freq, 0); chk("R1", tim_step, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2..R6 sweep: every address, both chip-select levels, eight patterns
    for (int i = 0; i < 8; i++) begin
      for (int a = 0; a < 4; a++) begin
        for (int c = 0; c < 2; c++) begin
          logic [DW-1:0] d;
          d = DW'((i * 16'h1357) ^ (a * 16'h0F1E) ^ (c * 16'h8001) ^ 16'hA5C3);
          do_write(2'(a), d, c[0]);
          if (c == 1) chk_bank("R6");
          else if (a == 0) chk_bank("R2");
          else if (a == 1) chk_bank("R3");
          else if (a == 2) chk_bank("R4");
          else chk_bank("R5");
        end
      end
    end
    // R10 targets untouched while enables stayed high
    chk("R10", ctr_freq, 0); chk("R10", off_freq, 0); chk("R10", tim_step, 0);

    // R7 held strobe loads once
    @(negedge clk);
    cmd_addr = 2'd0; cs_n = 1'b0; cmd_data = 16'h1111; wr_strb = 1'b1;
    @(negedge clk);
    m_lo = 16'h1111;
    chk_bank("R7");
    cmd_data = 16'h2222;
    repeat (3) @(negedge clk);
    chk_bank("R7");
    wr_strb = 1'b0;
    @(negedge clk);
    chk_bank("R7");

    do_write(2'd1, 16'hBEEF, 1'b0);
    do_write(2'd0, 16'hCAFE, 1'b0);

    // R8 pipelined enable, per target; R10 isolation
    for (int t = 0; t < 3; t++) begin
      logic [31:0] before_c, before_o, before_s;
      before_c = ctr_freq; before_o = off_freq; before_s = tim_step;
      ctr_n = (t != 0); off_n = (t != 1); tim_n = (t != 2);
      @(negedge clk);   // enable sampled at this edge
      chk("R8", ctr_freq, before_c); chk("R8", off_freq, before_o);
      chk("R8", tim_step, before_s);
      @(negedge clk);   // target loads here
      chk("R8", (t == 0) ? ctr_freq : (t == 1) ? off_freq : tim_step, {m_hi, m_lo});
      chk("R10", (t == 0) ? off_freq : ctr_freq, (t == 0) ? before_o : before_c);
      chk("R10", (t == 2) ? off_freq : tim_step, (t == 2) ? before_o : before_s);
      // R9 continuous reload follows a half update one clock later
      begin
        logic [31:0] prev;
        prev = {m_hi, m_lo};
        do_write(2'd0, DW'(16'h0101 * (t + 3)), 1'b0);
        chk("R9", (t == 0) ? ctr_freq : (t == 1) ? off_freq : tim_step, prev);
        @(negedge clk);
        chk("R9", (t == 0) ? ctr_freq : (t == 1) ? off_freq : tim_step, {m_hi, m_lo});
      end
      ctr_n = 1'b1; off_n = 1'b1; tim_n = 1'b1;
      repeat (2) @(negedge clk);
      begin
        logic [31:0] held;
        held = (t == 0) ? ctr_freq : (t == 1) ? off_freq : tim_step;
        do_write(2'd1, DW'(16'h3C00 + t), 1'b0);
        @(negedge clk);
        chk("R10", (t == 0) ? ctr_freq : (t == 1) ? off_freq : tim_step, held);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule